// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller. Pins are grouped into banks of up to 32. Each bank has its own registers:

- a sampled pin level;
- a direction mask;
- an output latch, changed through a write-one-to-set port and a write-one-to-clear port;
- separate rising-edge and falling-edge enables;
- a sticky edge-status word.

Software reaches these registers over a simple single-cycle register bus. Each pad is split into an input, an output value and an output enable.

Pad inputs pass through a two-stage synchroniser. An edge is found by comparing the synchronised value with its value one clock earlier. An edge on a pin whose matching enable is set latches that pin's status bit, and the bit stays set until software writes a one to it. One interrupt line is high while any status bit in any bank is set.

The register groups are interleaved. Each register kind takes a 12-byte group in which consecutive banks sit 4 bytes apart. The first three banks start at byte 0x000, and later banks start at byte 0x100 with the same layout.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it is sampled, every pad is an input (`pad_oe` all zero), `pad_out` is all zero and `irq` is low. Every register reads zero.
- R2: Register byte address = group base + register offset + lane × 4. The register offsets are level 0x00, direction 0x0C, set 0x18, clear 0x24, rise-enable 0x30, fall-enable 0x3C and status 0x48. For banks 0..2 the group base is 0x000 and the lane is the bank number. For banks 3..5 the group base is 0x100 and the lane is bank − 3. Word offsets of 0x54 and above within a group, and banks that are not built, read zero and ignore writes. `bus_rdata` is updated on the clock edge that samples a read and holds until the next read.
- R3: A direction bit of 1 drives `pad_oe` high for that pin, and 0 makes the pin an input. Only a write to that bank's direction address changes it.
- R4: Writing the set address ORs the written ones into the output latch. Zero bits leave outputs unchanged. Reading the set address returns the latch.
- R5: Writing the clear address forces each written-one bit of the output latch low. Reading the clear address also returns the latch.
- R6: A level read returns the synchronised pad value whatever the pin's direction. A read requested in the cycle after a pad change still returns the previous value.
- R7: A 0→1 change of the synchronised input sets the status bit when the rise enable is 1. A 1→0 change sets it when the fall enable is 1. An edge with its enable at 0 sets nothing.
- R8: Writing the status address clears each bit written as 1 and leaves bits written as 0. Writing all ones clears the whole bank.
- R9: If an edge lands in the same cycle as a status clear of that bit, the bit stays set.
- R10: `irq` is high exactly while any status bit of any bank is set, and it falls only after a bus write.
- R11: In the last bank, bits above the implemented pin count read zero in every register and drive no pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NUM_PINS | Pad input values |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| irq | output | 1 | OR of all edge-status bits |

## Verification
The hardest case to reach from the ports is an edge that arrives in the same clock as a write-one-to-clear of its status bit. It only occurs when the pad change and the bus write are offset by exactly the depth of the synchroniser plus the edge register.

The bench first sets the status bit with an earlier edge. It then changes the pad and issues the clear write two negative edges later, so that the write is sampled on the same edge that registers the new transition. A control clear with no edge follows, to show that the clear itself works.

Address interleave is covered by writing neighbouring lanes and checking that each read returns only its own bank.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BUS_AW    = 9;
    localparam int DW        = 32;
    localparam int MAX_BANKS = 6;
    localparam int GROUP_WORDS = 21;

    typedef enum logic [2:0] {
        RG_LEVEL = 3'd0,
        RG_DIR   = 3'd1,
        RG_SET   = 3'd2,
        RG_CLR   = 3'd3,
        RG_RISE  = 3'd4,
        RG_FALL  = 3'd5,
        RG_STAT  = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        logic [2:0] bank;
        reg_sel_e sel;
    } dec_t;

    typedef struct packed {
        logic [DW-1:0] level;
        logic [DW-1:0] dir;
        logic [DW-1:0] outv;
        logic [DW-1:0] rise;
        logic [DW-1:0] fall;
        logic [DW-1:0] stat;
    } bank_view_t;

    // Word index inside a group: register = word / 3, lane = word % 3.
    function automatic dec_t decode_addr(input logic [BUS_AW-1:0] a);
        dec_t        d;
        int unsigned w;
        w      = 32'(a[7:2]);
        d.hit  = (w < GROUP_WORDS);
        d.sel  = d.hit ? reg_sel_e'(3'(w / 3)) : RG_LEVEL;
        d.bank = 3'(w % 3) + (a[8] ? 3'd3 : 3'd0);
        return d;
    endfunction

    function automatic logic [DW-1:0] view_field(input bank_view_t v, input reg_sel_e s);
        logic [DW-1:0] r;
        case (s)
            RG_LEVEL:       r = v.level;
            RG_DIR:         r = v.dir;
            RG_SET, RG_CLR: r = v.outv;
            RG_RISE:        r = v.rise;
            RG_FALL:        r = v.fall;
            RG_STAT:        r = v.stat;
            default:        r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d_in;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  reg_sel_e        wsel,
    input  logic [DW-1:0]   wdata,
    input  logic [PINS-1:0] pin_s,
    output logic [PINS-1:0] out_o,
    output logic [PINS-1:0] oe_o,
    output bank_view_t      view_o,
    output logic            pending_o
);
    logic [PINS-1:0] dir_q, out_q, rise_q, fall_q, stat_q, prev_q;
    logic [PINS-1:0] wbits, stat_clr, rise_hit, fall_hit, stat_nxt;

    assign wbits    = wdata[PINS-1:0];
    assign stat_clr = (we && wsel == RG_STAT) ? wbits : '0;
    assign rise_hit = pin_s & ~prev_q & rise_q;
    assign fall_hit = ~pin_s & prev_q & fall_q;
    // New edges are ORed in after the clear, so an edge wins over a clear.
    assign stat_nxt = (stat_q & ~stat_clr) | rise_hit | fall_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            stat_q <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= pin_s;
            stat_q <= stat_nxt;
            if (we) begin
                case (wsel)
                    RG_DIR:  dir_q  <= wbits;
                    RG_SET:  out_q  <= out_q | wbits;
                    RG_CLR:  out_q  <= out_q & ~wbits;
                    RG_RISE: rise_q <= wbits;
                    RG_FALL: fall_q <= wbits;
                    default: ;
                endcase
            end
        end
    end

    assign out_o     = out_q;
    assign oe_o      = dir_q;
    assign pending_o = |stat_q;

    always_comb begin
        view_o       = '0;
        view_o.level = DW'(pin_s);
        view_o.dir   = DW'(dir_q);
        view_o.outv  = DW'(out_q);
        view_o.rise  = DW'(rise_q);
        view_o.fall  = DW'(fall_q);
        view_o.stat  = DW'(stat_q);
    end
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 100
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    localparam int NUM_BANKS = (NUM_PINS + DW - 1) / DW;

    dec_t                  dec;
    logic [NUM_PINS-1:0]   pin_s;
    bank_view_t            views [NUM_BANKS];
    logic [NUM_BANKS-1:0]  pend;
    logic [DW-1:0]         rd_next;

    assign dec = decode_addr(bus_addr);

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_in(pad_in),
        .q   (pin_s)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int PINS = (NUM_PINS - DW * b > DW) ? DW : NUM_PINS - DW * b;
        logic we_b;
        assign we_b = bus_sel && bus_wr && dec.hit && (dec.bank == 3'(b));

        gpio_bank #(.PINS(PINS)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .we       (we_b),
            .wsel     (dec.sel),
            .wdata    (bus_wdata),
            .pin_s    (pin_s[DW*b +: PINS]),
            .out_o    (pad_out[DW*b +: PINS]),
            .oe_o     (pad_oe[DW*b +: PINS]),
            .view_o   (views[b]),
            .pending_o(pend[b])
        );
    end

    always_comb begin
        rd_next = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec.hit && dec.bank == 3'(b))
                rd_next = view_field(views[b], dec.sel);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_sel && !bus_wr)
            bus_rdata <= rd_next;
    end

    assign irq = |pend;
endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
module gpio_banked_ctrl_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 100
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [BUS_AW-1:0]   bus_addr,
    input logic [DW-1:0]       bus_wdata,
    input logic [DW-1:0]       bus_rdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic                irq
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && pad_out == '0 && !irq));

    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr[7:2] >= 6'd21) |=> bus_rdata == '0);

    assert_oe_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr && bus_addr == 9'h00C) |=> $stable(pad_oe[0]));

    assert_set_drives_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 9'h018 && bus_wdata[0]) |=> pad_out[0]);

    assert_clr_drives_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 9'h024 && bus_wdata[0]) |=> !pad_out[0]);

    assert_irq_fall_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past((bus_sel && bus_wr) || rst));
endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .irq      (irq)
);

// File: tb/gpio_banked_ctrl_test.sv
module gpio_banked_ctrl_test;
    localparam int NP = 100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [8:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    gpio_banked_ctrl #(.NUM_PINS(NP)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // register codes: 0 level, 1 dir, 2 set, 3 clr, 4 rise, 5 fall, 6 status
    function automatic logic [8:0] ra(input int bank, input int rg);
        int base;
        base = (bank < 3) ? bank * 4 : 256 + (bank - 3) * 4;
        return 9'(base + rg * 12);
    endfunction

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pad_out", pad_out, '0);
        check("R1 irq", irq, 0);
        rd(ra(0, 1), v); check("R1 dir bank0", v, 0);
        rd(ra(3, 6), v); check("R1 status bank3", v, 0);
    endtask

    task automatic t_dir();
        logic [31:0] v;
        wr(ra(1, 1), 32'hA5A5_0001);
        @(negedge clk);
        check("R3 pad_oe bank1", pad_oe[63:32], 32'hA5A5_0001);
        check("R3 pad_oe bank0 untouched", pad_oe[31:0], 0);
        wr(ra(3, 1), 32'hFFFF_FFFF);
        check("R11 pad_oe bank3", pad_oe[99:96], 4'hF);
        rd(ra(3, 1), v); check("R11 dir bank3 readback", v, 32'h0000_000F);
    endtask

    task automatic t_set_clr();
        logic [31:0] v;
        wr(ra(0, 2), 32'h0000_00F0);
        check("R4 set F0", pad_out[31:0], 32'hF0);
        wr(ra(0, 2), 32'h0000_000F);
        check("R4 set accumulates", pad_out[31:0], 32'hFF);
        wr(ra(0, 3), 32'h0000_003C);
        check("R5 clear", pad_out[31:0], 32'hC3);
        wr(ra(0, 2), 32'h0);
        wr(ra(0, 3), 32'h0);
        check("R4 R5 zero bits ignored", pad_out[31:0], 32'hC3);
        rd(ra(0, 2), v); check("R4 set readback", v, 32'hC3);
        rd(ra(0, 3), v); check("R5 clear readback", v, 32'hC3);
        wr(ra(3, 2), 32'hFFFF_FFFF);
        rd(ra(3, 2), v); check("R11 set bank3 readback", v, 32'h0000_000F);
    endtask

    task automatic t_level();
        logic [31:0] v;
        pad_in[95:64] = 32'h1234_5678;
        pad_in[63:32] = 32'h0F0F_F0F0;
        rd(ra(2, 0), v); check("R6 level still old", v, 0);
        settle();
        rd(ra(2, 0), v); check("R6 level bank2", v, 32'h1234_5678);
        rd(ra(1, 0), v); check("R6 level bank1 with outputs", v, 32'h0F0F_F0F0);
        pad_in[95:64] = '0;
        pad_in[63:32] = '0;
        settle();
    endtask

    task automatic t_edges();
        logic [31:0] v;
        wr(ra(0, 4), 32'h0000_0010);
        wr(ra(0, 5), 32'h0000_0040);
        pad_in[4] = 1'b1; pad_in[5] = 1'b1; pad_in[6] = 1'b1;
        settle();
        rd(ra(0, 6), v); check("R7 rise latched, fall-only pin quiet", v, 32'h10);
        check("R10 irq high", irq, 1);
        pad_in[5] = 1'b0; pad_in[6] = 1'b0;
        settle();
        rd(ra(0, 6), v); check("R7 fall latched", v, 32'h50);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(ra(0, 6), 32'h0);
        rd(ra(0, 6), v); check("R8 zero write ignored", v, 32'h50);
        wr(ra(0, 6), 32'h10);
        rd(ra(0, 6), v); check("R8 single clear", v, 32'h40);
        wr(ra(0, 6), 32'hFFFF_FFFF);
        rd(ra(0, 6), v); check("R8 clear all", v, 0);
        check("R10 irq low", irq, 0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(ra(3, 4), 32'h4);
        pad_in[98] = 1'b1;
        settle();
        rd(ra(3, 6), v); check("R2 status bank3 at 0x148", v, 32'h4);
        check("R10 irq from bank3", irq, 1);
        wr(ra(0, 6), 32'hFFFF_FFFF);
        check("R10 irq kept by other bank", irq, 1);
        wr(ra(3, 6), 32'hFFFF_FFFF);
        check("R10 irq cleared", irq, 0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        pad_in[98] = 1'b0;
        settle();
        pad_in[98] = 1'b1;
        settle();
        pad_in[98] = 1'b0;
        settle();
        rd(ra(3, 6), v); check("R9 precondition set", v, 32'h4);
        pad_in[98] = 1'b1;
        @(negedge clk);
        wr(ra(3, 6), 32'h4);
        rd(ra(3, 6), v); check("R9 edge wins over clear", v, 32'h4);
        wr(ra(3, 6), 32'h4);
        rd(ra(3, 6), v); check("R9 plain clear works", v, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(ra(2, 4), 32'hCAFE_0001);
        rd(9'h038, v); check("R2 bank2 rise at 0x038", v, 32'hCAFE_0001);
        rd(9'h034, v); check("R2 bank1 rise lane separate", v, 0);
        wr(9'h110, 32'hFFFF_FFFF);
        rd(9'h110, v); check("R2 absent bank4 reads zero", v, 0);
        rd(9'h054, v); check("R2 unmapped word reads zero", v, 0);
        check("R2 absent write no pad effect", pad_oe[99:96], 4'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dir();
        t_set_clr();
        t_level();
        t_edges();
        t_w1c();
        t_irq();
        t_collision();
        t_map();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule